// File: doc/BRIEF.md
# DMA Address and Count Registers

This block holds the programming state of one word-oriented DMA channel: a word address into memory and a transfer counter with its direction and enable flags. Software sets the address without using the data bus. The value is carried on the CPU address lines of a register write, and one address line selects which half of the DMA address is loaded. Because the address comes from address decoding, it takes two writes to load it in full, one for each half.

The counter is loaded by a 16-bit data write. That write also supplies a direction flag and an enable flag. The block stores one more than the written count. A read of the counter returns the 14-bit count with the two top bits set to one.

While the channel is enabled, each transfer strobe from the DMA engine does two things: it moves the address on by one word and it takes one from the count. When the count reaches zero, the block raises a terminal-count flag and drops the enable. Bus arbitration and the peripheral handshake are outside this block.

Top module: `dma_regs`

## Requirements
- R1: After reset the address is 0, the count is 0, direction, enable and terminal count are 0, and the count readback is 16'hC000.
- R2: An address write with CPU address line 14 high copies CPU address bits [13:1] into DMA address bits [21:9]. DMA address bits [8:1] keep their value.
- R3: An address write with CPU address line 14 low copies CPU address bits [8:1] into DMA address bits [8:1]. DMA address bits [21:9] keep their value.
- R4: DMA address bit 0 is always 0.
- R5: A 16-bit count write does four things: it stores data[13:0]+1 modulo 2^14 as the count, it sets the direction flag from data bit 14, it sets the enable flag from data bit 15, and it clears terminal count.
- R6: A count write that is not a 16-bit access leaves the count, direction, enable and terminal count unchanged.
- R7: The count readback is {2'b11, count[13:0]}.
- R8: A transfer strobe while enable is set does two things: it adds 2 to the address, modulo 2^22, and it takes 1 from the count, modulo 2^14.
- R9: A strobe that brings the count to zero sets terminal count and clears enable. A strobe while enable is clear changes no register.
- R10: When a CPU write lands in the same cycle as an enabled strobe, the write wins for the register it targets. The register it does not target still takes the strobe's step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr_wr_i | input | 1 | CPU write to the DMA address register |
| cpu_a_i | input | 14 | CPU address lines 14 to 1 |
| cpu_cnt_wr_i | input | 1 | CPU write to the count register |
| cpu_word_i | input | 1 | Current access is 16 bits wide |
| cpu_wdata_i | input | 16 | CPU write data |
| cnt_rdata_o | output | 16 | Count register readback |
| xfer_stb_i | input | 1 | One word transferred by the DMA engine |
| dma_addr_o | output | 22 | Current DMA byte address (word aligned) |
| dma_dir_o | output | 1 | Direction flag |
| dma_en_o | output | 1 | Channel enable |
| dma_tc_o | output | 1 | Terminal count reached |

## Verification
Every result of this block comes from a register. An address load, a count load and a strobe step all show at the ports on the first rising edge after the cycle that presents them. The readback follows the stored count with no further delay. The bench drives each stimulus just after a rising edge and applies the same update to its model at the next edge. It then compares every output one nanosecond later, so each result is checked in the exact cycle it is due and never straddles an edge. The checks on priority present a write and a strobe together, to confirm that both updates land on that single edge.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

   // Default geometry of the channel
   localparam int DEF_ADDR_W  = 22;  // DMA byte address width
   localparam int DEF_LO_W    = 8;   // bits [LO_W:1] form the low half
   localparam int DEF_SEL_BIT = 14;  // CPU address line choosing the half
   localparam int DEF_CNT_W   = 14;  // transfer counter width

   // Next-state selector of the counter
   typedef enum logic [1:0] {
      CNT_HOLD = 2'd0,
      CNT_LOAD = 2'd1,
      CNT_STEP = 2'd2
   } cnt_op_e;

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
   parameter int ADDR_W  = dma_regs_pkg::DEF_ADDR_W,
   parameter int LO_W    = dma_regs_pkg::DEF_LO_W,
   parameter int SEL_BIT = dma_regs_pkg::DEF_SEL_BIT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [SEL_BIT:1]  a_i,
   input  logic              step_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int QW = ADDR_W - 1;         // word address width
   localparam int HI_W = QW - LO_W;        // width of the high half
   localparam logic [QW-1:0] WORD_ONE = 1;

   generate
      if (HI_W != SEL_BIT - 1) begin : g_bad_hi
         $error("high half must take every CPU line below the select line");
      end
      if (LO_W < 1 || LO_W >= QW) begin : g_bad_lo
         $error("low half width out of range");
      end
   endgenerate

   logic [QW-1:0] q;      // word address, byte bit 0 implied zero
   logic [QW-1:0] q_nxt;
   logic          sel_hi;

   assign sel_hi = a_i[SEL_BIT];

   always_comb begin
      q_nxt = q;
      if (wr_i) begin
         if (sel_hi) q_nxt[QW-1:LO_W] = a_i[HI_W:1];
         else        q_nxt[LO_W-1:0]  = a_i[LO_W:1];
      end else if (step_i) begin
         q_nxt = q + WORD_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

   assign addr_o = {q, 1'b0};

   AST_HI_LOAD_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && sel_hi |=> addr_o[LO_W:1] == $past(addr_o[LO_W:1])); // R2
   AST_LO_LOAD_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && !sel_hi |=> addr_o[ADDR_W-1:LO_W+1] == $past(addr_o[ADDR_W-1:LO_W+1])); // R3
   AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && !wr_i |=> addr_o[ADDR_W-1:1] == $past(addr_o[ADDR_W-1:1]) + WORD_ONE); // R8
   AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i && !wr_i |=> $stable(addr_o)); // R9

endmodule

// File: rtl/dma_count_reg.sv
module dma_count_reg #(
   parameter int CNT_W         = dma_regs_pkg::DEF_CNT_W,
   parameter bit LOAD_PLUS_ONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             word_i,
   input  logic [CNT_W+1:0] wdata_i,
   input  logic             stb_i,
   output logic             step_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             dir_o,
   output logic             en_o,
   output logic             tc_o,
   output logic [CNT_W+1:0] rdata_o
);
   import dma_regs_pkg::*;

   localparam int DIR_BIT = CNT_W;
   localparam int EN_BIT  = CNT_W + 1;
   localparam logic [CNT_W-1:0] CNT_ONE = 1;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("counter width too small");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, cnt_n, load_val;
   logic             dir_q, dir_n, en_q, en_n, tc_q, tc_n;
   logic             load;
   cnt_op_e          op;

   generate
      if (LOAD_PLUS_ONE) begin : g_bias
         assign load_val = wdata_i[CNT_W-1:0] + CNT_ONE;
      end else begin : g_plain
         assign load_val = wdata_i[CNT_W-1:0];
      end
   endgenerate

   assign load   = wr_i & word_i;
   assign step_o = stb_i & en_q;

   always_comb begin
      if (load)        op = CNT_LOAD;
      else if (step_o) op = CNT_STEP;
      else             op = CNT_HOLD;
   end

   always_comb begin
      cnt_n = cnt_q;
      dir_n = dir_q;
      en_n  = en_q;
      tc_n  = tc_q;
      case (op)
         CNT_LOAD: begin
            cnt_n = load_val;
            dir_n = wdata_i[DIR_BIT];
            en_n  = wdata_i[EN_BIT];
            tc_n  = 1'b0;
         end
         CNT_STEP: begin
            cnt_n = cnt_q - CNT_ONE;
            if (cnt_q == CNT_ONE) begin
               en_n = 1'b0;
               tc_n = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
         en_q  <= 1'b0;
         tc_q  <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         dir_q <= dir_n;
         en_q  <= en_n;
         tc_q  <= tc_n;
      end
   end

   assign cnt_o   = cnt_q;
   assign dir_o   = dir_q;
   assign en_o    = en_q;
   assign tc_o    = tc_q;
   assign rdata_o = {2'b11, cnt_q};

   AST_BYTE_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i && !word_i && !stb_i |=> $stable(cnt_q) && $stable(en_q) && $stable(dir_q) && $stable(tc_q)); // R6
   AST_TC_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_o) |-> !en_o); // R9
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_o && !load |=> $stable(cnt_o) && $stable(tc_o)); // R9
   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      stb_i && en_o && !load |=> cnt_o == $past(cnt_o) - CNT_ONE); // R8

endmodule

// File: rtl/dma_regs.sv
module dma_regs #(
   parameter int ADDR_W        = dma_regs_pkg::DEF_ADDR_W,
   parameter int LO_W          = dma_regs_pkg::DEF_LO_W,
   parameter int SEL_BIT       = dma_regs_pkg::DEF_SEL_BIT,
   parameter int CNT_W         = dma_regs_pkg::DEF_CNT_W,
   parameter bit LOAD_PLUS_ONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_addr_wr_i,
   input  logic [SEL_BIT:1]  cpu_a_i,
   input  logic              cpu_cnt_wr_i,
   input  logic              cpu_word_i,
   input  logic [CNT_W+1:0]  cpu_wdata_i,
   output logic [CNT_W+1:0]  cnt_rdata_o,
   input  logic              xfer_stb_i,
   output logic [ADDR_W-1:0] dma_addr_o,
   output logic              dma_dir_o,
   output logic              dma_en_o,
   output logic              dma_tc_o
);
   logic             step;
   logic [CNT_W-1:0] cnt_unused_view;

   dma_count_reg #(
      .CNT_W        (CNT_W),
      .LOAD_PLUS_ONE(LOAD_PLUS_ONE)
   ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (cpu_cnt_wr_i),
      .word_i (cpu_word_i),
      .wdata_i(cpu_wdata_i),
      .stb_i  (xfer_stb_i),
      .step_o (step),
      .cnt_o  (cnt_unused_view),
      .dir_o  (dma_dir_o),
      .en_o   (dma_en_o),
      .tc_o   (dma_tc_o),
      .rdata_o(cnt_rdata_o)
   );

   dma_addr_reg #(
      .ADDR_W (ADDR_W),
      .LO_W   (LO_W),
      .SEL_BIT(SEL_BIT)
   ) u_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (cpu_addr_wr_i),
      .a_i   (cpu_a_i),
      .step_i(step),
      .addr_o(dma_addr_o)
   );

   AST_EN_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_en_o) |-> $past(cpu_cnt_wr_i && cpu_word_i)); // R5
   AST_READBACK_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_cnt_wr_i && !xfer_stb_i |=> $stable(cnt_rdata_o)); // R7
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_stb_i |=> !dma_addr_o[0]); // R4

endmodule

// File: tb/tb_dma_regs.sv
module tb_dma_regs;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cpu_addr_wr_i, cpu_cnt_wr_i, cpu_word_i, xfer_stb_i;
   logic [14:1] cpu_a_i;
   logic [15:0] cpu_wdata_i, cnt_rdata_o;
   logic [21:0] dma_addr_o;
   logic        dma_dir_o, dma_en_o, dma_tc_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   // model state
   logic [21:0] m_addr;
   logic [13:0] m_cnt;
   logic        m_dir, m_en, m_tc;

   always #2 clk = ~clk;

   dma_regs dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_addr_wr_i(cpu_addr_wr_i), .cpu_a_i(cpu_a_i),
      .cpu_cnt_wr_i(cpu_cnt_wr_i), .cpu_word_i(cpu_word_i),
      .cpu_wdata_i(cpu_wdata_i), .cnt_rdata_o(cnt_rdata_o),
      .xfer_stb_i(xfer_stb_i), .dma_addr_o(dma_addr_o),
      .dma_dir_o(dma_dir_o), .dma_en_o(dma_en_o), .dma_tc_o(dma_tc_o)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      chk(tag, "addr",  {10'd0, dma_addr_o}, {10'd0, m_addr});
      chk(tag, "rdata", {16'd0, cnt_rdata_o}, {16'd0, 2'b11, m_cnt});
      chk(tag, "dir",   {31'd0, dma_dir_o}, {31'd0, m_dir});
      chk(tag, "en",    {31'd0, dma_en_o},  {31'd0, m_en});
      chk(tag, "tc",    {31'd0, dma_tc_o},  {31'd0, m_tc});
      chk("R4", "addr bit0", {31'd0, dma_addr_o[0]}, 32'd0);
   endtask

   // one cycle: drive, update model at the edge, compare 1 ns later
   task automatic cyc(input bit wa, input logic [14:1] a, input bit wc, input bit word,
                      input logic [15:0] d, input bit stb, input string tag);
      bit step;
      cpu_addr_wr_i = wa; cpu_a_i = a; cpu_cnt_wr_i = wc;
      cpu_word_i = word; cpu_wdata_i = d; xfer_stb_i = stb;
      @(posedge clk);
      step = stb && m_en;
      if (wa) begin
         if (a[14]) m_addr[21:9] = a[13:1];
         else       m_addr[8:1]  = a[8:1];
      end else if (step) begin
         m_addr = m_addr + 22'd2;
      end
      if (wc && word) begin
         m_cnt = d[13:0] + 14'd1;
         m_dir = d[14];
         m_en  = d[15];
         m_tc  = 1'b0;
      end else if (step) begin
         m_cnt = m_cnt - 14'd1;
         if (m_cnt == 14'd0) begin
            m_en = 1'b0;
            m_tc = 1'b1;
         end
      end
      #1;
      chk_all(tag);
   endtask

   function automatic logic [14:1] hi_sel(input logic [12:0] v);
      return {1'b1, v};
   endfunction

   function automatic logic [14:1] lo_sel(input logic [7:0] v);
      return {6'b0, v};
   endfunction

   initial begin
      #100000;
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0a17));
      rst_n = 1'b0;
      cpu_addr_wr_i = 0; cpu_cnt_wr_i = 0; cpu_word_i = 0; xfer_stb_i = 0;
      cpu_a_i = '0; cpu_wdata_i = '0;
      m_addr = '0; m_cnt = '0; m_dir = 0; m_en = 0; m_tc = 0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      chk_all("R1");
      chk("R1", "rdata reset", {16'd0, cnt_rdata_o}, 32'h0000_C000);

      // R2 / R3: half loads
      cyc(1, hi_sel(13'h1ABC), 0, 1, 16'h0, 0, "R2");
      chk("R2", "hi field", {10'd0, dma_addr_o}, {10'd0, 13'h1ABC, 9'd0});
      cyc(1, lo_sel(8'h5A), 0, 1, 16'h0, 0, "R3");
      chk("R3", "lo field", {10'd0, dma_addr_o}, {10'd0, 13'h1ABC, 8'h5A, 1'b0});
      cyc(1, hi_sel(13'h0013), 0, 1, 16'h0, 0, "R2");
      cyc(1, {1'b0, 5'h1F, 8'hC3}, 0, 1, 16'h0, 0, "R3");

      // R5 / R7: load 5 -> count 6, enabled, direction 0
      cyc(0, '0, 1, 1, 16'h8005, 0, "R5");
      chk("R7", "readback", {16'd0, cnt_rdata_o}, 32'h0000_C006);
      // R6: byte write to count ignored
      cyc(0, '0, 1, 0, 16'h4123, 0, "R6");
      chk("R6", "count after byte write", {16'd0, cnt_rdata_o}, 32'h0000_C006);

      // R8 / R9: run to terminal count
      for (int i = 0; i < 5; i++) cyc(0, '0, 0, 1, 16'h0, 1, "R8");
      cyc(0, '0, 0, 1, 16'h0, 1, "R9");
      chk("R9", "tc set", {31'd0, dma_tc_o}, 32'd1);
      chk("R9", "en cleared", {31'd0, dma_en_o}, 32'd0);
      cyc(0, '0, 0, 1, 16'h0, 1, "R9");
      cyc(0, '0, 0, 1, 16'h0, 1, "R9");

      // R5: load wraps to zero, direction set, enable clear
      cyc(0, '0, 1, 1, 16'h7FFF, 0, "R5");
      chk("R5", "wrapped count", {16'd0, cnt_rdata_o}, 32'h0000_C000);

      // R10: priority on same-cycle write and strobe
      cyc(0, '0, 1, 1, 16'h8002, 0, "R5");
      cyc(1, lo_sel(8'h10), 0, 1, 16'h0, 1, "R10");
      chk("R10", "count stepped", {16'd0, cnt_rdata_o}, 32'h0000_C002);
      cyc(0, '0, 1, 1, 16'h8009, 1, "R10");
      chk("R10", "count loaded", {16'd0, cnt_rdata_o}, 32'h0000_C00A);

      // R8: address wrap at the top
      cyc(1, hi_sel(13'h1FFF), 0, 1, 16'h0, 0, "R2");
      cyc(1, lo_sel(8'hFF), 0, 1, 16'h0, 0, "R3");
      cyc(0, '0, 0, 1, 16'h0, 1, "R8");
      chk("R8", "address wrap", {10'd0, dma_addr_o}, 32'd0);

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] r;
         r = $urandom;
         cyc(r[0] & r[1], r[15:2], r[16] & r[17] & r[18], r[19] | r[20],
             {r[21], r[22] | r[23], 10'd0, r[27:24]}, r[28] | r[29], "R8");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule